// File: doc/BRIEF.md
# Camera Sensor Register Configuration Sequencer

After reset this block brings up a CMOS image sensor over a two-wire serial control bus. The bus is I2C-like, with one clock line and one open-drain data line. A small internal ROM holds 16-bit entries, each a register address byte followed by a value byte. The sequencer walks the ROM from index 0. Each ordinary entry becomes one three-byte write: the write ID 0x42, the register address, then the value.

Two marker codes steer the walk. 0xFFF0 inserts a settle pause of `DELAY_CYC` clocks, for instance after a soft reset of the sensor. 0xFFFF ends the table and raises the finished flag. A resend pulse, which arrives already debounced, restarts the walk from index 0. If a write is in flight at that moment, the write completes before the restart.

The block also supplies a master clock to the sensor at half the system clock rate. It holds the sensor's reset pin inactive (high) and its power-down pin inactive (low).

The ROM contents are placeholders. They select RGB565 output, keep the pixel clock, line-valid and frame-sync outputs running, and load the six colour matrix coefficients.

Top module: `cam_cfg_seq`

## Requirements
- R1: Each ordinary entry produces one bus write, framed by a start condition and a stop condition. A start is the data line falling while the clock is high; a stop is the data line rising while the clock is high. The write carries three bytes, MSB first, each bit sampled on a rising edge of `sioc_o`: the byte 0x42, then entry[15:8], then entry[7:0].
- R2: After each byte a ninth bit slot follows, during which the data line is released. The line is only ever pulled low or released, so it reads high through the external pull-up.
- R3: Inside a write, consecutive rising edges of `sioc_o` that carry data bits lie exactly 4*`QTR_CYC` clocks apart.
- R4: Entries are written in ROM order. The entry 0xFFF0 produces no write. It makes the gap between the stop of the previous write and the start of the next at least `DELAY_CYC` clocks; gaps between other writes stay below that.
- R5: The entry 0xFFFF sets `cfg_done_o`. The flag stays high until a resend arrives. While it is high no further write occurs, and both bus lines stay high.
- R6: When `resend_i` is high on a clock edge, `cfg_done_o` is low after that edge. The sequence restarts at ROM index 0. A write already in flight completes intact first, and only that one write. A resend during the settle pause restarts at once.
- R7: `sensor_reset_o` is always 1 and `sensor_pwdn_o` is always 0.
- R8: `sensor_mclk_o` toggles on every system clock edge after reset.
- R9: During reset `sioc_o` is high, the data line is released and `cfg_done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resend_i | input | 1 | Debounced request to rerun the configuration |
| sioc_o | output | 1 | Serial bus clock |
| siod_io | inout | 1 | Serial bus data, open drain (drives 0 or releases) |
| sensor_reset_o | output | 1 | Sensor reset pin, held inactive high |
| sensor_pwdn_o | output | 1 | Sensor power-down pin, held inactive low |
| sensor_mclk_o | output | 1 | Sensor master clock, half the system clock |
| cfg_done_o | output | 1 | Every ROM entry has been written |

## Verification
A resend can land in the same cycle that a write is in flight, or while the settle pause is counting. The design then has to let one write finish and also begin the new sequence. The bench provokes this with resend pulses at random offsets from a fixed seed, and directed pulses inside the pause and while the flag is high. It judges each run from the decoded bus traffic alone. Every write must be well formed, at most one extra write may appear before the restart, and the last thirteen writes must equal the full ROM sequence.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned N_BYTES   = 3;
  localparam int unsigned FRAME_W   = N_BYTES * (BYTE_W + 1);
  localparam int unsigned ROM_DEPTH = 16;
  localparam int unsigned IDX_W     = $clog2(ROM_DEPTH);

  localparam logic [15:0]       END_MARK   = 16'hFFFF;
  localparam logic [15:0]       DELAY_MARK = 16'hFFF0;
  localparam logic [BYTE_W-1:0] WR_ID      = 8'h42;

  typedef enum logic [1:0] {ST_FETCH, ST_SEND, ST_DELAY, ST_DONE} seq_st_e;
endpackage

// File: rtl/cam_cfg_rom.sv
module cam_cfg_rom
  import cam_cfg_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [15:0]      entry_o
);
  // placeholder settings: soft reset, pause, RGB565, sync outputs, colour matrix
  always_comb begin
    unique case (idx_i)
      4'd0:    entry_o = 16'h1280;
      4'd1:    entry_o = DELAY_MARK;
      4'd2:    entry_o = 16'h1204;
      4'd3:    entry_o = 16'h40D0;
      4'd4:    entry_o = 16'h1500;
      4'd5:    entry_o = 16'h8C00;
      4'd6:    entry_o = 16'h4FB3;
      4'd7:    entry_o = 16'h50B3;
      4'd8:    entry_o = 16'h5100;
      4'd9:    entry_o = 16'h523D;
      4'd10:   entry_o = 16'h53A7;
      4'd11:   entry_o = 16'h54E4;
      4'd12:   entry_o = 16'h589E;
      4'd13:   entry_o = 16'h1101;
      default: entry_o = END_MARK;
    endcase
  end
endmodule

// File: rtl/sccb_wr_engine.sv
module sccb_wr_engine #(
  parameter int unsigned QTR_CYC = 32,
  parameter int unsigned FRAME_W = 27
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               scl_o,
  output logic               sda_low_o,
  output logic               done_o
);
  localparam int unsigned STOP_SLOT = FRAME_W + 1;
  localparam int unsigned SLOT_W    = $clog2(STOP_SLOT + 1);
  localparam int unsigned QC_W      = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

  logic               act;
  logic [SLOT_W-1:0]  slot;
  logic [1:0]         ph;
  logic [QC_W-1:0]    qcnt;
  logic [FRAME_W-1:0] frame_q;
  logic               scl_c, sda_c;

  wire q_end    = (qcnt == QC_W'(QTR_CYC - 1));
  wire bit_slot = (slot != '0) && (slot != SLOT_W'(STOP_SLOT));

  // slot 0 = start, 1..FRAME_W = bits (4 phases each), STOP_SLOT = stop
  always_comb begin
    scl_c = 1'b1;
    sda_c = 1'b0;
    if (act) begin
      if (slot == '0) begin
        scl_c = (ph != 2'd3);
        sda_c = (ph != 2'd0);
      end else if (slot == SLOT_W'(STOP_SLOT)) begin
        scl_c = (ph != 2'd0);
        sda_c = ~ph[1];
      end else begin
        scl_c = ph[1];
        sda_c = ~frame_q[FRAME_W-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act       <= 1'b0;
      slot      <= '0;
      ph        <= '0;
      qcnt      <= '0;
      frame_q   <= '0;
      done_o    <= 1'b0;
      scl_o     <= 1'b1;
      sda_low_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      scl_o     <= scl_c;
      sda_low_o <= sda_c;
      if (!act) begin
        if (start_i) begin
          act     <= 1'b1;
          slot    <= '0;
          ph      <= '0;
          qcnt    <= '0;
          frame_q <= frame_i;
        end
      end else if (q_end) begin
        qcnt <= '0;
        ph   <= ph + 2'd1;
        if (ph == 2'd3) begin
          if (bit_slot) frame_q <= frame_q << 1;
          if (slot == SLOT_W'(STOP_SLOT)) begin
            act    <= 1'b0;
            done_o <= 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end
      end else begin
        qcnt <= qcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_cfg_seq.sv
module cam_cfg_seq
  import cam_cfg_pkg::*;
#(
  parameter int unsigned QTR_CYC   = 32,
  parameter int unsigned DELAY_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic resend_i,
  output logic sioc_o,
  inout  wire  siod_io,
  output logic sensor_reset_o,
  output logic sensor_pwdn_o,
  output logic sensor_mclk_o,
  output logic cfg_done_o
);
  localparam int unsigned DL_W = $clog2(DELAY_CYC + 1);

  seq_st_e            st;
  logic [IDX_W-1:0]   idx;
  logic [15:0]        entry;
  logic [DL_W-1:0]    dly;
  logic               pend, eng_start, eng_done, sda_low, mclk_q;
  logic [FRAME_W-1:0] frame;

  cam_cfg_rom u_rom (.idx_i(idx), .entry_o(entry));

  assign frame = {WR_ID, 1'b1, entry[15:8], 1'b1, entry[7:0], 1'b1};

  sccb_wr_engine #(.QTR_CYC(QTR_CYC), .FRAME_W(FRAME_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .frame_i   (frame),
    .scl_o     (sioc_o),
    .sda_low_o (sda_low),
    .done_o    (eng_done)
  );

  assign siod_io        = sda_low ? 1'b0 : 1'bz;
  assign sensor_reset_o = 1'b1;
  assign sensor_pwdn_o  = 1'b0;
  assign sensor_mclk_o  = mclk_q;

  wire restart = pend | resend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_FETCH;
      idx        <= '0;
      dly        <= '0;
      pend       <= 1'b0;
      eng_start  <= 1'b0;
      cfg_done_o <= 1'b0;
      mclk_q     <= 1'b0;
    end else begin
      mclk_q    <= ~mclk_q;
      eng_start <= 1'b0;
      pend      <= restart;
      if (resend_i) cfg_done_o <= 1'b0;
      unique case (st)
        ST_FETCH: begin
          if (restart) begin
            idx  <= '0;
            pend <= 1'b0;
          end else if (entry == END_MARK) begin
            st         <= ST_DONE;
            cfg_done_o <= 1'b1;
          end else if (entry == DELAY_MARK) begin
            dly <= '0;
            st  <= ST_DELAY;
          end else begin
            eng_start <= 1'b1;
            st        <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (eng_done) begin
            st <= ST_FETCH;
            if (restart) begin
              idx  <= '0;
              pend <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (restart) begin
            idx  <= '0;
            pend <= 1'b0;
            st   <= ST_FETCH;
          end else if (dly == DL_W'(DELAY_CYC - 1)) begin
            idx <= idx + 1'b1;
            st  <= ST_FETCH;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        ST_DONE: begin
          if (resend_i) begin
            idx  <= '0;
            pend <= 1'b0;
            st   <= ST_FETCH;
          end
        end
        default: st <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/cam_cfg_seq_chk.sv
module cam_cfg_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic resend_i,
  input logic sioc_o,
  input logic sensor_mclk_o,
  input logic cfg_done_o
);
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o && !resend_i |=> cfg_done_o); // R5

  AST_DONE_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |-> sioc_o); // R5

  AST_RESEND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resend_i |=> !cfg_done_o); // R6

  AST_MCLK_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> sensor_mclk_o != $past(sensor_mclk_o)); // R8
endmodule

bind cam_cfg_seq cam_cfg_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .resend_i      (resend_i),
  .sioc_o        (sioc_o),
  .sensor_mclk_o (sensor_mclk_o),
  .cfg_done_o    (cfg_done_o)
);

// File: tb/cam_cfg_seq_bench.sv
module cam_cfg_seq_bench;
  localparam int Q   = 4;
  localparam int DLY = 200;
  localparam int NWR = 13;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic resend = 1'b0;
  logic sioc, rst_pin, pwdn_pin, mclk, done;
  wire  siod;

  pullup (siod);

  always #10 clk = ~clk;

  cam_cfg_seq #(.QTR_CYC(Q), .DELAY_CYC(DLY)) u_cam_cfg_seq (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .resend_i       (resend),
    .sioc_o         (sioc),
    .siod_io        (siod),
    .sensor_reset_o (rst_pin),
    .sensor_pwdn_o  (pwdn_pin),
    .sensor_mclk_o  (mclk),
    .cfg_done_o     (done)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] tb_write(input int k);
    logic [15:0] w [NWR] = '{16'h1280, 16'h1204, 16'h40D0, 16'h1500, 16'h8C00,
                             16'h4FB3, 16'h50B3, 16'h5100, 16'h523D, 16'h53A7,
                             16'h54E4, 16'h589E, 16'h1101};
    return w[k];
  endfunction

  function automatic logic [26:0] tb_frame(input logic [15:0] w);
    return {8'h42, 1'b1, w[15:8], 1'b1, w[7:0], 1'b1};
  endfunction

  // bus monitor
  longint     cyc = 0, last_rise = 0, cur_start = 0;
  logic       p_scl = 1'b1, p_sda = 1'b1, p_mclk = 1'b0, in_txn = 1'b0;
  logic [27:0] shf = '0;
  int         nbits = 0, txn_n = 0;
  logic [26:0] lg_frame [256];
  int         lg_bits  [256];
  longint     lg_start [256], lg_stop [256];
  int         sp_bad = 0, sp_ok = 0, pin_bad = 0, mclk_bad = 0;
  bit         wd_hit = 1'b0;

  always @(negedge clk) begin
    logic sda_v;
    sda_v = (siod === 1'b0) ? 1'b0 : 1'b1;
    cyc++;
    if (rst_ni) begin
      if (rst_pin !== 1'b1 || pwdn_pin !== 1'b0) pin_bad++;
      if (cyc > 8 && mclk === p_mclk) mclk_bad++;
      if (p_scl && sioc && p_sda && !sda_v) begin
        in_txn = 1'b1; nbits = 0; shf = '0; cur_start = cyc;
      end else if (p_scl && sioc && !p_sda && sda_v && in_txn) begin
        in_txn = 1'b0;
        if (txn_n < 256) begin
          lg_frame[txn_n] = shf[27:1];
          lg_bits[txn_n]  = nbits;
          lg_start[txn_n] = cur_start;
          lg_stop[txn_n]  = cyc;
        end
        txn_n++;
      end else if (!p_scl && sioc && in_txn) begin
        if (nbits >= 1 && nbits <= 26) begin
          if (cyc - last_rise != 4 * Q) sp_bad++; else sp_ok++;
        end
        shf = {shf[26:0], sda_v};
        nbits++;
        last_rise = cyc;
      end
    end
    p_scl = sioc; p_sda = sda_v; p_mclk = mclk;
    if (cyc > 180000 && !wd_hit) begin
      wd_hit = 1'b1;
      chk(1'b0, "WD", "watchdog expired", cyc, 180000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_done();
    int t;
    t = 0;
    @(negedge clk);
    while (done !== 1'b1 && t < 40000) begin @(negedge clk); t++; end
    chk(done === 1'b1, "R5", "finished flag reached", done, 1);
  endtask

  task automatic pulse_resend(input int len);
    @(negedge clk) resend = 1'b1;
    repeat (len) @(negedge clk);
    resend = 1'b0;
  endtask

  task automatic verify_run(input int base, input bit exact);
    int n, off;
    n = txn_n - base;
    off = n - NWR;
    if (exact) chk(n == NWR, "R6", "write count, no write in flight", n, NWR);
    else chk(n == NWR || n == NWR + 1, "R6", "write count after restart", n, NWR);
    if (off < 0 || off > 1) return;
    if (off == 1) chk(lg_bits[base] == 28, "R6", "in-flight write intact", lg_bits[base], 28);
    for (int k = 0; k < NWR; k++) begin
      logic [26:0] f;
      f = lg_frame[base + off + k];
      chk(lg_bits[base + off + k] == 28, "R1", "clock pulses per write", lg_bits[base + off + k], 28);
      chk({f[26:19], f[17:10], f[8:1]} == {8'h42, tb_write(k)}, "R1", $sformatf("write %0d bytes", k),
          {f[26:19], f[17:10], f[8:1]}, {8'h42, tb_write(k)});
      chk({f[18], f[9], f[0]} == 3'b111, "R2", "ninth bits released", {f[18], f[9], f[0]}, 3'b111);
      chk(f == tb_frame(tb_write(k)), "R4", "ROM order", f, tb_frame(tb_write(k)));
    end
    chk(lg_start[base + off + 1] - lg_stop[base + off] >= DLY, "R4", "pause after soft reset",
        lg_start[base + off + 1] - lg_stop[base + off], DLY);
    chk(lg_start[base + off + 2] - lg_stop[base + off + 1] < DLY, "R4", "no pause elsewhere",
        lg_start[base + off + 2] - lg_stop[base + off + 1], DLY);
  endtask

  initial begin
    int base, w;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(sioc === 1'b1, "R9", "sioc in reset", sioc, 1);
    chk(siod === 1'b1, "R9", "data released in reset", siod, 1);
    chk(done === 1'b0, "R9", "done in reset", done, 0);
    chk(rst_pin === 1'b1 && pwdn_pin === 1'b0, "R7", "sensor pins in reset", {rst_pin, pwdn_pin}, 2'b10);
    rst_ni = 1'b1;

    wait_done();
    verify_run(0, 1'b1);

    base = txn_n;
    repeat (300) @(negedge clk);
    chk(txn_n == base, "R5", "no writes after end", txn_n, base);
    chk(sioc === 1'b1 && siod === 1'b1, "R5", "bus idle after end", {sioc, siod}, 2'b11);
    chk(done === 1'b1, "R5", "flag holds", done, 1);

    // directed: resend while finished, held 3 cycles
    base = txn_n;
    pulse_resend(3);
    chk(done === 1'b0, "R6", "flag cleared by resend", done, 0);
    wait_done();
    verify_run(base, 1'b1);

    // directed: resend inside the settle pause
    pulse_resend(1);
    base = txn_n;
    while (txn_n == base) @(negedge clk);
    repeat (DLY / 2) @(negedge clk);
    base = txn_n;
    pulse_resend(1);
    chk(done === 1'b0, "R6", "flag low after pause resend", done, 0);
    wait_done();
    verify_run(base, 1'b1);

    // random resend points while writes are in progress
    for (int it = 0; it < 5; it++) begin
      pulse_resend(1);
      w = 50 + ($urandom % 5000);
      repeat (w) @(negedge clk);
      base = txn_n;
      pulse_resend(1 + ($urandom % 3));
      wait_done();
      verify_run(base, 1'b0);
    end

    chk(sp_bad == 0 && sp_ok > 0, "R3", "bit clock spacing", sp_bad, 0);
    chk(pin_bad == 0, "R7", "sensor reset/power-down pins", pin_bad, 0);
    chk(mclk_bad == 0, "R8", "master clock toggles", mclk_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule